// File: doc/BRIEF.md
# Segmented Kernel Address Translator

This block turns a 32-bit virtual address into either a physical address, a request to an external page-table walker, or a fault. The top four address bits pick one of sixteen 256 MB segments. Software sets each segment to one of two modes. In linear mode the segment number is replaced by a 4-bit base and the low 28 bits pass through unchanged. In paged mode the whole address goes to the walker, and no translation happens here.

A small write port loads a 16-bit segment mode word, two 32-bit base words and a translation-enable bit. While translation is off, every address passes straight through. This is the state the system boots in. While translation is on, an access flagged as user mode may only reach segments 0 to A. Anything at or above 0xB0000000 is refused with a range fault. The walker reports a miss on its own input, and the block turns that into a fault with a separate cause code.

All results come out on registered outputs. They appear one clock after the request is sampled.

Top module: `seg_xlate`

## Requirements
- R1: After reset all outputs are low, translation is off, the mode word is zero and both base words are zero.
- R2: With translation off, a request yields out_valid one cycle later with out_paddr equal to the virtual address, whatever req_user is.
- R3: With translation on and mode bit n set (segment n = vaddr[31:28]), out_paddr is the segment's 4-bit base followed by vaddr[27:0], one cycle later.
- R4: The base for segment k (k = 0..7) sits at bits [4k+3:4k] of the low base word; the base for segment 8+k sits at bits [4k+3:4k] of the high base word.
- R5: With translation on and mode bit n clear, the request yields walk_req with walk_vaddr equal to the virtual address, and no out_valid.
- R6: With translation on, a user request to segment B or above yields fault with fault_cause 0 and fault_vaddr equal to the address, and neither out_valid nor walk_req. Kernel requests reach all segments.
- R7: A pulse on walk_fail yields fault with fault_cause 1 and fault_vaddr equal to walk_fail_vaddr one cycle later. A user range fault in the same cycle takes precedence and is the one reported.
- R8: A config write uses cfg_sel 0 for the mode word (cfg_wdata[15:0]), 1 for the low base word, 2 for the high base word, and 3 for the enable (cfg_wdata[0]). A request sampled on the same edge as a write uses the old values. The next request uses the new ones.
- R9: out_valid and walk_req are never high together, and neither is high in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config target: 0 mode, 1 base low, 2 base high, 3 enable |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user-mode access |
| walk_fail | input | 1 | Walker reports a miss |
| walk_fail_vaddr | input | 32 | Address the walker failed on |
| out_valid | output | 1 | Translated address valid |
| out_paddr | output | 32 | Physical address |
| walk_req | output | 1 | Forward to page walker |
| walk_vaddr | output | 32 | Address for the walker |
| fault | output | 1 | Fault reported |
| fault_cause | output | 1 | 0 = user range, 1 = walk miss |
| fault_vaddr | output | 32 | Faulting virtual address |

## Verification
The checker watches every clock for the following rules:
- An address passes through while translation is off.
- The low 28 bits survive in linear segments.
- Paged segments are forwarded intact.
- User accesses above segment A are faulted.
- A walker miss becomes a cause-1 fault.
- The two result outputs never overlap.

The checker cannot show that the right base nibble is substituted for each segment, or that a write lands in the right word. Only the bench's vectors show those. The bench's directed cases also cover the ordering of a write against a lookup on the same edge, and a walker miss that collides with a range fault.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW       = 32,
  parameter int SEGW     = 4,
  parameter logic [3:0] USER_TOP = 4'hB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_user,
  input  logic          walk_fail,
  input  logic [AW-1:0] walk_fail_vaddr,
  output logic          out_valid,
  output logic [AW-1:0] out_paddr,
  output logic          walk_req,
  output logic [AW-1:0] walk_vaddr,
  output logic          fault,
  output logic          fault_cause,
  output logic [AW-1:0] fault_vaddr
);
  localparam int NSEG = 1 << SEGW;
  localparam int OFFW = AW - SEGW;

  logic [NSEG-1:0]   mode_q;
  logic [31:0]       blo_q, bhi_q;
  logic              en_q;

  logic [SEGW-1:0]   seg;
  logic [2*32-1:0]   bases;
  logic [SEGW-1:0]   base;
  logic              lin, viol;

  assign seg   = req_vaddr[AW-1 -: SEGW];
  assign bases = {bhi_q, blo_q};
  assign base  = bases[{seg, 2'b00} +: SEGW];
  assign lin   = mode_q[seg];
  assign viol  = en_q && req_user && (seg >= USER_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      blo_q  <= '0;
      bhi_q  <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: mode_q <= cfg_wdata[NSEG-1:0];
        2'd1: blo_q  <= cfg_wdata;
        2'd2: bhi_q  <= cfg_wdata;
        default: en_q <= cfg_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_paddr   <= '0;
      walk_req    <= 1'b0;
      walk_vaddr  <= '0;
      fault       <= 1'b0;
      fault_cause <= 1'b0;
      fault_vaddr <= '0;
    end else begin
      out_valid <= 1'b0;
      walk_req  <= 1'b0;
      fault     <= 1'b0;
      if (req_valid) begin
        if (!en_q) begin
          out_valid <= 1'b1;
          out_paddr <= req_vaddr;
        end else if (viol) begin
          fault       <= 1'b1;
          fault_cause <= 1'b0;
          fault_vaddr <= req_vaddr;
        end else if (lin) begin
          out_valid <= 1'b1;
          out_paddr <= {base, req_vaddr[OFFW-1:0]};
        end else begin
          walk_req   <= 1'b1;
          walk_vaddr <= req_vaddr;
        end
      end
      if (walk_fail && !(req_valid && viol)) begin
        fault       <= 1'b1;
        fault_cause <= 1'b1;
        fault_vaddr <= walk_fail_vaddr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        req_user,
  input logic        walk_fail,
  input logic [31:0] walk_fail_vaddr,
  input logic        en_q,
  input logic [15:0] mode_q,
  input logic        out_valid,
  input logic [31:0] out_paddr,
  input logic        walk_req,
  input logic [31:0] walk_vaddr,
  input logic        fault,
  input logic        fault_cause,
  input logic [31:0] fault_vaddr
);
  logic user_bad;
  assign user_bad = en_q && req_user && (req_vaddr[31:28] >= 4'hB);

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !en_q |=> out_valid && out_paddr == $past(req_vaddr));

  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && en_q && !user_bad && mode_q[req_vaddr[31:28]]
    |=> out_valid && out_paddr[27:0] == $past(req_vaddr[27:0]));

  p_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && en_q && !user_bad && !mode_q[req_vaddr[31:28]]
    |=> walk_req && !out_valid && walk_vaddr == $past(req_vaddr));

  p_user_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && user_bad
    |=> fault && !fault_cause && !out_valid && !walk_req && fault_vaddr == $past(req_vaddr));

  p_walk_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fail && !(req_valid && user_bad)
    |=> fault && fault_cause && fault_vaddr == $past(walk_fail_vaddr));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, walk_req}));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && !walk_req);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_user(req_user), .walk_fail(walk_fail), .walk_fail_vaddr(walk_fail_vaddr),
  .en_q(en_q), .mode_q(mode_q), .out_valid(out_valid), .out_paddr(out_paddr),
  .walk_req(walk_req), .walk_vaddr(walk_vaddr), .fault(fault),
  .fault_cause(fault_cause), .fault_vaddr(fault_vaddr)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_user = 1'b0;
  logic        walk_fail = 1'b0;
  logic [31:0] walk_fail_vaddr = '0;
  logic        out_valid, walk_req, fault, fault_cause;
  logic [31:0] out_paddr, walk_vaddr, fault_vaddr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_user(req_user),
    .walk_fail(walk_fail), .walk_fail_vaddr(walk_fail_vaddr),
    .out_valid(out_valid), .out_paddr(out_paddr), .walk_req(walk_req),
    .walk_vaddr(walk_vaddr), .fault(fault), .fault_cause(fault_cause),
    .fault_vaddr(fault_vaddr)
  );

  // kind: 0 translated, 1 walk, 2 range fault (cause 0), 3 walk-miss fault (cause 1)
  // entry: {user, kind[1:0], vaddr[31:0], expected[31:0]}
  localparam int NV = 14;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'hC000_0000, 32'h4000_0000},
    {1'b0, 2'd0, 32'hC123_4567, 32'h4123_4567},
    {1'b0, 2'd0, 32'hF000_0010, 32'h0000_0010},
    {1'b0, 2'd0, 32'hE800_0000, 32'h8800_0000},
    {1'b0, 2'd0, 32'hB000_0004, 32'hB000_0004},
    {1'b0, 2'd1, 32'hD004_000C, 32'hD004_000C},
    {1'b1, 2'd1, 32'h0000_2000, 32'h0000_2000},
    {1'b1, 2'd0, 32'h3ABC_DEF0, 32'h7ABC_DEF0},
    {1'b1, 2'd0, 32'h4000_0100, 32'h4000_0100},
    {1'b1, 2'd1, 32'hAFFF_FFFC, 32'hAFFF_FFFC},
    {1'b1, 2'd2, 32'hB000_0000, 32'hB000_0000},
    {1'b1, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 2'd2, 32'hC000_0000, 32'hC000_0000},
    {1'b0, 2'd1, 32'h1234_5678, 32'h1234_5678}
  };

  task automatic check(input string req, input logic [1:0] kind, input logic [31:0] exp);
    logic [31:0] act;
    logic ok;
    checks++;
    case (kind)
      2'd0: begin act = out_paddr;   ok = out_valid && !walk_req && !fault && act == exp; end
      2'd1: begin act = walk_vaddr;  ok = walk_req && !out_valid && !fault && act == exp; end
      2'd2: begin act = fault_vaddr; ok = fault && !fault_cause && !out_valid && !walk_req && act == exp; end
      default: begin act = fault_vaddr; ok = fault && fault_cause && act == exp; end
    endcase
    if (!ok) begin
      errors++;
      $display("FAIL %s: kind=%0d act=%h ov=%b wr=%b f=%b c=%b exp=%h", req, kind, act,
               out_valid, walk_req, fault, fault_cause, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic user, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_user = user; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, outputs low
    checks++;
    if (out_valid || walk_req || fault) begin
      errors++;
      $display("FAIL R1: act=%b%b%b exp=000", out_valid, walk_req, fault);
    end
    // R1 R2: pass-through after reset, user flag ignored
    lookup(1'b1, 32'hFFFF_FFFF);
    check("R1/R2 pass-through user", 2'd0, 32'hFFFF_FFFF);
    lookup(1'b0, 32'hD004_000C);
    check("R2 pass-through kernel", 2'd0, 32'hD004_000C);

    // R8 R4: configure
    cfg_write(2'd0, 32'h0000_D818);
    cfg_write(2'd1, 32'h0004_7000);
    cfg_write(2'd2, 32'h0804_B000);
    cfg_write(2'd3, 32'h0000_0001);

    // R3 R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][66], VEC[i][63:32]);
      check("R3/R4/R5/R6 vector", VEC[i][65:64], VEC[i][31:0]);
    end

    // R9: idle cycle gives nothing
    @(negedge clk);
    checks++;
    if (out_valid || walk_req) begin
      errors++;
      $display("FAIL R9 idle: act=%b%b exp=00", out_valid, walk_req);
    end

    // R8: write and lookup on the same edge use old base for segment C
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0809_B000;
    req_valid = 1'b1; req_user = 1'b0; req_vaddr = 32'hC000_0040;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R8 same-edge old base", 2'd0, 32'h4000_0040);
    lookup(1'b0, 32'hC000_0040);
    check("R8 new base", 2'd0, 32'h9000_0040);

    // R7: walker miss alone
    @(negedge clk);
    walk_fail = 1'b1; walk_fail_vaddr = 32'hD123_0000;
    @(negedge clk);
    walk_fail = 1'b0;
    check("R7 walk miss", 2'd3, 32'hD123_0000);

    // R7: range fault wins over concurrent walker miss
    @(negedge clk);
    walk_fail = 1'b1; walk_fail_vaddr = 32'hD555_0000;
    req_valid = 1'b1; req_user = 1'b1; req_vaddr = 32'hE000_0008;
    @(negedge clk);
    walk_fail = 1'b0; req_valid = 1'b0;
    check("R7 range priority", 2'd2, 32'hE000_0008);

    // R8: mode word rewrite makes segment D linear
    cfg_write(2'd0, 32'h0000_F818);
    lookup(1'b0, 32'hD004_000C);
    check("R8 mode rewrite", 2'd0, 32'h0004_000C);

    // R2 R8: disable again restores pass-through, user unchecked
    cfg_write(2'd3, 32'h0000_0000);
    lookup(1'b1, 32'hC000_0000);
    check("R2 disabled again", 2'd0, 32'hC000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule